// File: doc/BRIEF.md
# Oscillator-Stop Sticky Flag Register

This block supervises a slow oscillator from a fast, free-running supervisory clock. The oscillator arrives as a one-cycle enable pulse (`oscTick`) in the supervisory domain. The block decides whether the oscillator is running or stopped. Three conditions count as a stop:

- no enable pulse for a parameterised number of supervisory cycles;
- the host's oscillator-disable control bit is set;
- a supply-too-low indication is present.

The block keeps an 8-bit status register with one meaningful bit, the stop flag. The flag is sticky and is raised when the block leaves reset. After that, it is raised again on every transition of the oscillator from running to stopped. Software can clear the flag but can never set it. A host reads and writes the register through a plain port: address, write strobe, write data, and combinational read data.

The flag is edge triggered. One continuous stop raises it only once. The running state is re-armed only after a fresh oscillator pulse, seen while neither the disable bit nor the low-supply input is active. If a stop and a host clear arrive in the same cycle, the stop wins.

Top module: `osf_flag_reg`

## Requirements
- R1: After reset is released, `stopFlag` is 1, `oscRunning` is 0, and a read of address 0x09 returns 0x80.
- R2: A read of address 0x09 returns the flag in bit 7, with bits 6..0 always 0. Any other address reads 0x00.
- R3: The oscillator is running and a pulse is sampled at clock edge E0. If no further pulse follows, `oscRunning` stays 1 and the flag is not raised through edge E0+TIMEOUT. At edge E0+TIMEOUT+1, `oscRunning` falls and the flag becomes 1.
- R4: `oscDisable` is sampled high at an edge while the oscillator is running. At that edge, `oscRunning` falls and the flag becomes 1.
- R5: `supplyLow` is sampled high at an edge while the oscillator is running. At that edge, `oscRunning` falls and the flag becomes 1.
- R6: A write to address 0x09 with bit 7 = 0 clears the flag. A write to 0x09 with bit 7 = 1 leaves the flag unchanged. Writes to any other address leave the flag unchanged.
- R7: A stop event and a clearing write in the same cycle leave the flag at 1.
- R8: A flag cleared during a stop that continues stays 0 for as long as that stop lasts.
- R9: `oscRunning` rises at the edge that samples `oscTick` = 1 while `oscDisable` = 0 and `supplyLow` = 0. A pulse sampled while either of those inputs is 1 leaves `oscRunning` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisory clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| oscTick | input | 1 | One-cycle pulse per oscillator edge, in the clk domain |
| oscDisable | input | 1 | Host control bit that halts the oscillator |
| supplyLow | input | 1 | Supply too weak to sustain oscillation |
| regAddr | input | ADDR_W (8) | Register address |
| regWr | input | 1 | Write strobe |
| regWdata | input | DATA_W (8) | Write data |
| regRdata | output | DATA_W (8) | Combinational read data for `regAddr` |
| stopFlag | output | 1 | Current stop flag |
| oscRunning | output | 1 | Supervisor's running/stopped state |

## Verification
The assertions assume that `oscTick`, `oscDisable`, `supplyLow` and the register port are already synchronous to `clk`, and that `oscTick` is a single-cycle pulse. The bench changes every input only at falling edges. It widens `oscTick` to exactly one cycle per pulse. It shortens the timeout to 32 cycles so that a watchdog expiry can be observed at its exact edge. The bench keeps pulse gaps short wherever the oscillator must stay running, so that a stall only happens where a test intends one.

// File: rtl/osf_pkg.sv
package osf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic stopEvt;  // running -> stopped transition this cycle
    logic clrReq;   // host write of 0 to the flag bit
    logic rdSel;    // status address selected
  } osf_strobe_t;
endpackage

// File: rtl/osf_ctrl.sv
module osf_ctrl
  import osf_pkg::*;
#(
  parameter int TIMEOUT = 4096,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              oscDisable,
  input  logic              supplyLow,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              wrFlagBit,
  output osf_strobe_t       strobe,
  output logic              oscRunning
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] idleCnt;
  logic stalled;
  logic stopCond;
  logic armOk;
  logic running;

  // Idle watchdog: saturates at the timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (oscTick) begin
      idleCnt <= '0;
    end else if (idleCnt != CNT_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign stalled  = (idleCnt == CNT_MAX);
  assign stopCond = oscDisable | supplyLow | stalled;
  assign armOk    = oscTick & ~oscDisable & ~supplyLow;

  // Run state: starts stopped, re-armed only by a fresh pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (running) begin
      if (stopCond) running <= 1'b0;
    end else if (armOk) begin
      running <= 1'b1;
    end
  end

  assign oscRunning     = running;
  assign strobe.stopEvt = running & stopCond;
  assign strobe.rdSel   = (regAddr == STAT_ADDR);
  assign strobe.clrReq  = regWr & strobe.rdSel & ~wrFlagBit;
endmodule

// File: rtl/osf_dp.sv
module osf_dp
  import osf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  osf_strobe_t       strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic              stopFlag
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic flag;

  // Sticky flag: power-up value 1, set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b1;
    end else if (strobe.stopEvt) begin
      flag <= 1'b1;
    end else if (strobe.clrReq) begin
      flag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (strobe.rdSel) regRdata[FLAG_BIT] = flag;
  end

  assign stopFlag = flag;
endmodule

// File: rtl/osf_flag_reg.sv
module osf_flag_reg
  import osf_pkg::*;
#(
  parameter int TIMEOUT = 4096,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              oscDisable,
  input  logic              supplyLow,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              stopFlag,
  output logic              oscRunning
);
  localparam int FLAG_BIT = DATA_W - 1;

  osf_strobe_t strobe;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[FLAG_BIT-1:0];

  osf_ctrl #(
    .TIMEOUT(TIMEOUT),
    .ADDR_W(ADDR_W),
    .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .oscTick(oscTick),
    .oscDisable(oscDisable),
    .supplyLow(supplyLow),
    .regAddr(regAddr),
    .regWr(regWr),
    .wrFlagBit(regWdata[FLAG_BIT]),
    .strobe(strobe),
    .oscRunning(oscRunning)
  );

  osf_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .regRdata(regRdata),
    .stopFlag(stopFlag)
  );
endmodule

// File: rtl/osf_flag_chk.sv
module osf_flag_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h09
) (
  input logic              clk,
  input logic              rstN,
  input logic              oscTick,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              stopFlag,
  input logic              oscRunning
);
  localparam int FLAG_BIT = DATA_W - 1;

  // R2: low bits never read as 1
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[FLAG_BIT-1:0] == '0);

  // R2: the status address reflects the flag
  a_r2_read_flag: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == STAT_ADDR) |-> (regRdata[FLAG_BIT] == stopFlag));

  // R3/R4/R5/R7: every fall of the running state leaves the flag set
  a_r7_stop_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oscRunning) |-> stopFlag);

  // R8: the flag rises only together with a stop transition
  a_r8_rise_on_stop_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopFlag) |-> $fell(oscRunning));

  // R6: without a clearing write the flag holds
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stopFlag && !(regWr && regAddr == STAT_ADDR && !regWdata[FLAG_BIT])) |=> stopFlag);

  // R9: running is only entered after a sampled pulse
  a_r9_rearm_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscRunning) |-> $past(oscTick));
endmodule

bind osf_flag_reg osf_flag_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .oscTick(oscTick),
  .regAddr(regAddr),
  .regWr(regWr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .stopFlag(stopFlag),
  .oscRunning(oscRunning)
);

// File: tb/osf_flag_reg_test.sv
module osf_flag_reg_test;
  localparam int TO = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscTick = 1'b0;
  logic oscDisable = 1'b0;
  logic supplyLow = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic stopFlag;
  logic oscRunning;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  osf_flag_reg #(.TIMEOUT(TO)) uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .oscDisable(oscDisable),
    .supplyLow(supplyLow), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .stopFlag(stopFlag),
    .oscRunning(oscRunning)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // Pulse sampled at the next edge; returns just after that edge
  task automatic pulse();
    @(negedge clk);
    oscTick = 1'b1;
    @(negedge clk);
    oscTick = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    @(negedge clk);
    check("R1 flag", {7'b0, stopFlag}, 8'h01);
    check("R1 running", {7'b0, oscRunning}, 8'h00);
    readReg(8'h09, d); check("R1 read", d, 8'h80);
    readReg(8'h08, d); check("R2 other addr", d, 8'h00);
    readReg(8'h89, d); check("R2 alias addr", d, 8'h00);
  endtask

  task automatic testClearWrite();
    logic [7:0] d;
    pulse();
    check("R9 arm", {7'b0, oscRunning}, 8'h01);
    writeReg(8'h0A, 8'h00);
    check("R6 other addr write", {7'b0, stopFlag}, 8'h01);
    writeReg(8'h09, 8'h80);
    check("R6 write one", {7'b0, stopFlag}, 8'h01);
    writeReg(8'h09, 8'h7F);
    check("R6 clear", {7'b0, stopFlag}, 8'h00);
    writeReg(8'h09, 8'hFF);
    readReg(8'h09, d); check("R2 read cleared", d, 8'h00);
  endtask

  task automatic testStall();
    for (int i = 0; i < 6; i++) begin
      pulse();
      repeat (6) @(negedge clk);
    end
    check("R3 live no flag", {7'b0, stopFlag}, 8'h00);
    check("R3 live running", {7'b0, oscRunning}, 8'h01);
    pulse();
    repeat (TO) @(negedge clk);
    check("R3 before timeout flag", {7'b0, stopFlag}, 8'h00);
    check("R3 before timeout run", {7'b0, oscRunning}, 8'h01);
    @(negedge clk);
    check("R3 timeout flag", {7'b0, stopFlag}, 8'h01);
    check("R3 timeout run", {7'b0, oscRunning}, 8'h00);
  endtask

  task automatic testOnce();
    writeReg(8'h09, 8'h00);
    repeat (100) @(negedge clk);
    check("R8 single set", {7'b0, stopFlag}, 8'h00);
    pulse();
    check("R9 rearm", {7'b0, oscRunning}, 8'h01);
  endtask

  task automatic testDisable();
    @(negedge clk);
    oscDisable = 1'b1;
    @(negedge clk);
    check("R4 flag", {7'b0, stopFlag}, 8'h01);
    check("R4 running", {7'b0, oscRunning}, 8'h00);
    pulse();
    check("R9 no arm disabled", {7'b0, oscRunning}, 8'h00);
    oscDisable = 1'b0;
    writeReg(8'h09, 8'h00);
    pulse();
    check("R9 arm after disable", {7'b0, oscRunning}, 8'h01);
  endtask

  task automatic testSupply();
    @(negedge clk);
    supplyLow = 1'b1;
    @(negedge clk);
    check("R5 flag", {7'b0, stopFlag}, 8'h01);
    check("R5 running", {7'b0, oscRunning}, 8'h00);
    pulse();
    check("R9 no arm low supply", {7'b0, oscRunning}, 8'h00);
    supplyLow = 1'b0;
    pulse();
    writeReg(8'h09, 8'h00);
    check("R5 cleared", {7'b0, stopFlag}, 8'h00);
  endtask

  task automatic testSetWins();
    pulse();
    check("R7 running", {7'b0, oscRunning}, 8'h01);
    @(negedge clk);
    oscDisable = 1'b1;
    regAddr = 8'h09; regWdata = 8'h00; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
    check("R7 set wins", {7'b0, stopFlag}, 8'h01);
    oscDisable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testClearWrite();
    testStall();
    testOnce();
    testDisable();
    testSupply();
    testSetWins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule